// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block generates the array address for a memory that serves data in bursts of four words. A burst opens when either of two start strobes is sampled low on a rising clock edge. One strobe comes from the processor side and the other from the memory controller. When a burst opens, the full word address is loaded. The two least significant bits of that address seed the beat counter.

After the load, the block produces the remaining burst addresses itself. It moves to the next beat only in a cycle where the advance input is low. When advance is high it holds the current address, so the burst is suspended rather than restarted.

A strap input, not registered, chooses how the two low bits move. In linear order they count upward modulo four. In interleaved order they are the seed XORed with a beat count. Alongside the address, the block reports what kind of cycle was last accepted.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, and until the first valid start, `cycle_kind` is 0 (deselect) and `addr_out` is 0.
- R2: When `proc_start_n` is sampled low with `enable_n` low, the whole of `addr_in` is loaded and `cycle_kind` becomes 1 (begin). This also holds when `ctrl_start_n` is low in the same cycle, and when advance is low in that cycle.
- R3: When `enable_n` is high, a low `proc_start_n` is ignored. The cycle then behaves as if that strobe were high.
- R4: When `ctrl_start_n` is sampled low without a processor-side start, two cases apply. With `enable_n` low, a burst begins (kind 1) from `addr_in`. With `enable_n` high, the burst ends and `cycle_kind` becomes 0. In that deselect case `addr_out` holds its last value.
- R5: In a cycle with no start, the result depends on the burst state and on `advance_n`:
  - In an open burst with `advance_n` low, the beat steps and `cycle_kind` becomes 2 (continue).
  - In an open burst with `advance_n` high, the address holds and `cycle_kind` becomes 3 (suspend).
  - With no open burst, `cycle_kind` stays 0 whatever `advance_n` is.
- R6: When `order_intlv` is 0, the two low address bits are the seed plus the beat count, modulo four. For example, seed 01 gives 01, 10, 11, 00.
- R7: When `order_intlv` is 1, the two low bits are the seed XORed with the beat count 00, 01, 10, 11. For example, seed 01 gives 01, 00, 11, 10.
- R8: After the fourth beat, further advances wrap back to the first address and repeat the same order.
- R9: `order_intlv` is not sampled by the clock. A change reaches `addr_out` in the same cycle, with no clock edge needed.
- R10: `addr_out` bits above bit 1 keep their loaded value until the next start, whatever `addr_in` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | ADDR_W | External word address |
| proc_start_n | input | 1 | Processor-side start strobe, active low |
| ctrl_start_n | input | 1 | Controller-side start strobe, active low |
| advance_n | input | 1 | Step to the next beat when low |
| enable_n | input | 1 | Primary chip enable, active low |
| order_intlv | input | 1 | Static strap: 0 linear, 1 interleaved |
| addr_out | output | ADDR_W | Current array address |
| cycle_kind | output | 2 | 0 deselect, 1 begin, 2 continue, 3 suspend |

## Verification
A start strobe and the advance input can both be active in the same cycle. The processor-side strobe can also arrive in the same cycle as a high primary enable. The bench provokes both combinations:
- A start is driven with advance held low. It is judged by a begin kind together with the freshly loaded, unstepped address.
- A processor strobe is driven while the enable is high and a burst is open. The result must be an ordinary step, with no reload from the changed address input.

Both strobes low together are driven as well, and must produce a single begin.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              proc_start_n,
  input  logic              ctrl_start_n,
  input  logic              advance_n,
  input  logic              enable_n,
  input  logic              order_intlv,
  output logic [ADDR_W-1:0] addr_out,
  output logic [1:0]        cycle_kind
);
  localparam logic [1:0] K_DESEL = 2'd0;
  localparam logic [1:0] K_BEGIN = 2'd1;
  localparam logic [1:0] K_CONT  = 2'd2;
  localparam logic [1:0] K_SUSP  = 2'd3;

  logic [ADDR_W-3:0] hi_q;
  logic [1:0]        seed_q, step_q, kind_q, lo;
  logic              live_q;
  logic              take_p, take_c, load, drop;

  assign take_p = !proc_start_n && !enable_n;
  assign take_c = !take_p && !ctrl_start_n;
  assign load   = take_p || (take_c && !enable_n);
  assign drop   = take_c && enable_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      seed_q <= '0;
      step_q <= '0;
      live_q <= 1'b0;
      kind_q <= K_DESEL;
    end else if (load) begin
      hi_q   <= addr_in[ADDR_W-1:2];
      seed_q <= addr_in[1:0];
      step_q <= '0;
      live_q <= 1'b1;
      kind_q <= K_BEGIN;
    end else if (drop) begin
      live_q <= 1'b0;
      kind_q <= K_DESEL;
    end else if (live_q) begin
      if (!advance_n) begin
        step_q <= step_q + 2'd1;
        kind_q <= K_CONT;
      end else begin
        kind_q <= K_SUSP;
      end
    end else begin
      kind_q <= K_DESEL;
    end
  end

  assign lo         = order_intlv ? (seed_q ^ step_q) : (seed_q + step_q);
  assign addr_out   = {hi_q, lo};
  assign cycle_kind = kind_q;

  a_r2_begin_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_start_n && !enable_n) |=> (cycle_kind == K_BEGIN && addr_out == $past(addr_in)));

  a_r3_no_begin_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_n && ctrl_start_n) |=> (cycle_kind != K_BEGIN));

  a_r4_ctrl_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_start_n && enable_n) |=> (cycle_kind == K_DESEL));

  a_r5_suspend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((proc_start_n || enable_n) && ctrl_start_n && advance_n && $stable(order_intlv))
      |=> (addr_out == $past(addr_out)));

  a_r10_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    ((proc_start_n || enable_n) && ctrl_start_n)
      |=> (addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2])));
endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] addr_in = '0;
  logic        proc_start_n = 1'b1, ctrl_start_n = 1'b1, advance_n = 1'b1;
  logic        enable_n = 1'b1, order_intlv = 1'b0;
  logic [14:0] addr_out;
  logic [1:0]  cycle_kind;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  burst_addr_seq #(.ADDR_W(15)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
    .proc_start_n(proc_start_n), .ctrl_start_n(ctrl_start_n),
    .advance_n(advance_n), .enable_n(enable_n), .order_intlv(order_intlv),
    .addr_out(addr_out), .cycle_kind(cycle_kind)
  );

  // {proc_n, ctrl_n, adv_n, en_n, order}, addr_in, expected addr, expected kind, requirement
  localparam int NV = 22;
  localparam logic [40:0] VEC [NV] = '{
    {5'b01100, 15'h1235, 15'h1235, 2'd1, 4'd2},  // R2 processor start
    {5'b11000, 15'h5555, 15'h1236, 2'd2, 4'd6},  // R6 linear
    {5'b11000, 15'h5555, 15'h1237, 2'd2, 4'd6},
    {5'b11000, 15'h5555, 15'h1234, 2'd2, 4'd8},  // R8
    {5'b11000, 15'h5555, 15'h1235, 2'd2, 4'd8},  // wrap to first
    {5'b11100, 15'h5555, 15'h1235, 2'd3, 4'd5},  // R5 suspend
    {5'b11000, 15'h5555, 15'h1236, 2'd2, 4'd10}, // R10 upper bits fixed
    {5'b01010, 15'h7777, 15'h1237, 2'd2, 4'd3},  // R3 strobe with enable high
    {5'b10110, 15'h7777, 15'h1237, 2'd0, 4'd4},  // R4 deselect
    {5'b11000, 15'h5555, 15'h1237, 2'd0, 4'd5},  // advance while idle
    {5'b10101, 15'h2A01, 15'h2A01, 2'd1, 4'd4},  // controller start
    {5'b11001, 15'h5555, 15'h2A00, 2'd2, 4'd7},  // R7 interleaved
    {5'b11001, 15'h5555, 15'h2A03, 2'd2, 4'd7},
    {5'b11001, 15'h5555, 15'h2A02, 2'd2, 4'd7},
    {5'b11001, 15'h5555, 15'h2A01, 2'd2, 4'd8},
    {5'b00001, 15'h0C12, 15'h0C12, 2'd1, 4'd2},  // both strobes, advance low
    {5'b11001, 15'h5555, 15'h0C13, 2'd2, 4'd7},
    {5'b11101, 15'h5555, 15'h0C13, 2'd3, 4'd5},
    {5'b11001, 15'h5555, 15'h0C10, 2'd2, 4'd7},
    {5'b01001, 15'h7FFF, 15'h7FFF, 2'd1, 4'd2},  // start with advance low
    {5'b01100, 15'h4003, 15'h4003, 2'd1, 4'd6},
    {5'b11000, 15'h5555, 15'h4000, 2'd2, 4'd6}
  };

  task automatic check(input int req, input logic [14:0] ea, input logic [1:0] ek);
    total++;
    if (addr_out !== ea || cycle_kind !== ek) begin
      bad++;
      $display("FAIL R%0d: addr=%h kind=%0d expected addr=%h kind=%0d",
               req, addr_out, cycle_kind, ea, ek);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 check(1, 15'h0, 2'd0);  // R1 in reset
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #2 check(1, 15'h0, 2'd0);  // R1 idle after reset
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {proc_start_n, ctrl_start_n, advance_n, enable_n, order_intlv} = VEC[i][40:36];
      addr_in = VEC[i][35:21];
      @(posedge clk);
      #2 check(int'(VEC[i][3:0]), VEC[i][20:6], VEC[i][5:4]);
    end
    @(negedge clk);
    order_intlv = 1'b1;
    #1 check(9, 15'h4002, 2'd2);  // R9 strap acts without a clock edge
    order_intlv = 1'b0;
    #1 check(9, 15'h4000, 2'd2);
    rst_n = 1'b0;
    #1 check(1, 15'h0, 2'd0);     // R1 reset in mid-burst
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule